// File: doc/BRIEF.md
# Pulse-Width Single-Wire Frame Receiver

This block receives frames from a single-wire link on which each data bit is carried as a low pulse. The bit value depends on how long that pulse lasts. Every bit starts with a falling edge. The receiver looks at the line a fixed time after that edge. A short pulse (about 0.5 ms) has already ended at that moment, so the line is high and the bit is a one. A long pulse (about 1.0 ms) is still low, so the bit is a zero.

A frame begins with a low period much longer than any data pulse. The rising edge that ends this period is the start marker. After the marker come 96 data bits, grouped as twelve bytes. When the frame ends, the line returns to its low idle level.

The asynchronous input passes through a synchroniser before edge detection. A single counter measures the time since the last falling edge, and all timing thresholds come from that counter. Decoded bits are shifted into a frame register. When the 96th bit arrives, the twelve bytes are copied to an output register and a one-cycle valid strobe is raised. All delays are given in microseconds and converted to clock cycles from a clock-frequency parameter. If the line stops producing bits partway through a frame, the partial frame is dropped and a one-cycle error strobe is raised.

Top module: `pulse_frame_rx`

## Requirements
- R1: Each bit is decided by the synchronised line level SAMPLE_US after its falling edge: high gives 1, low gives 0.
- R2: A low period of at least SYNC_US that ends in a rising edge is a start marker. It clears the bit count and arms reception. A shorter low period is not a start marker.
- R3: Once 96 bits have been received after a start marker, frame_valid_o is high for exactly one cycle, and the receiver then waits for a new start marker.
- R4: frame_data_o[8k+7:8k] holds byte k, where byte 0 is the first byte received. Within each byte, the first bit received is bit 7.
- R5: frame_data_o changes only in a cycle where frame_valid_o is high, and it holds its value at all other times.
- R6: If at least one bit and fewer than 96 bits have been received and no falling edge arrives within TIMEOUT_US of the last one, frame_err_o is high for one cycle, the partial frame is dropped, and frame_valid_o stays low.
- R7: While the first bit after a start marker is awaited, the line may stay quiet for any length of time without raising frame_err_o.
- R8: Pulses that arrive without a preceding start marker raise neither frame_valid_o nor frame_err_o and leave frame_data_o unchanged.
- R9: A start marker in the middle of a frame drops the partial bits, and reception restarts from bit 0.
- R10: While rst_ni is low and just after reset, frame_valid_o and frame_err_o are 0 and frame_data_o is all zeros.
- R11: A line that stays at low idle after a frame produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Asynchronous single-wire data line |
| frame_valid_o | output | 1 | One-cycle strobe: a complete frame has been received |
| frame_data_o | output | 8*NBYTES | Received bytes, byte k at bits [8k+7:8k] |
| frame_err_o | output | 1 | One-cycle strobe: a partial frame timed out |

## Verification
Pulse widths are randomised on both sides of the sample point. A receiver that samples at the wrong time, or that lets a fast following edge restart the timer before sampling, would therefore flip bits. Byte values are random and also include the all-ones and all-zeros patterns, which catch reversed byte order or LSB-first shifting. The directed cases cover:
- a frame cut off after 40 bits, where a missing timeout would leave the receiver hung and a repeated timeout would give several error strobes;
- a long quiet gap before bit 0, where an over-eager timeout would abort a valid frame;
- a restart marker halfway through a frame, which a design without restart would turn into a corrupted frame;
- pulses with no marker and a low period just under the marker threshold, which a loose marker detector would accept as a frame.

// File: rtl/pfr_pkg.sv
package pfr_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RECV = 1'b1
  } rx_state_e;

  function automatic int cyc_from_us(input longint hz, input longint us);
    return int'((hz * us) / 64'd1_000_000);
  endfunction

endpackage

// File: rtl/pfr_line_sync.sv
module pfr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o,
  output logic fall_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= line_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], line_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign line_o = sync_q[STAGES-1];
  assign fall_o = prev_q & ~sync_q[STAGES-1];
  assign rise_o = ~prev_q & sync_q[STAGES-1];
endmodule

// File: rtl/pfr_pulse_timer.sv
module pfr_pulse_timer #(
  parameter int SAMPLE_CYC  = 75,
  parameter int SYNC_CYC    = 200,
  parameter int TIMEOUT_CYC = 500,
  localparam int CNT_W      = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic fall_i,
  input  logic rise_i,
  output logic sample_o,
  output logic bit_o,
  output logic sync_o,
  output logic tmo_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;

  // cycles since last falling edge, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  cnt_q <= '0;
    else if (fall_i)                              cnt_q <= '0;
    else if (cnt_q != CNT_W'(TIMEOUT_CYC))        cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= 1'b0;
    else if (fall_i)   pend_q <= 1'b1;
    else if (sample_o) pend_q <= 1'b0;
  end

  assign sample_o = pend_q && !fall_i && (cnt_q == CNT_W'(SAMPLE_CYC));
  assign bit_o    = line_i;
  // low length is the count at the rising edge
  assign sync_o   = rise_i && (cnt_q >= CNT_W'(SYNC_CYC));
  assign tmo_o    = !fall_i && (cnt_q == CNT_W'(TIMEOUT_CYC - 1));
endmodule

// File: rtl/pfr_shifter.sv
module pfr_shifter #(
  parameter int NBITS = 96,
  localparam int BCNT_W = $clog2(NBITS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [NBITS-1:0]  shreg_o,
  output logic [BCNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_o <= '0;
      cnt_o   <= '0;
    end else if (clr_i) begin
      cnt_o   <= '0;
    end else if (shift_i) begin
      shreg_o <= {shreg_o[NBITS-2:0], bit_i};
      cnt_o   <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/pulse_frame_rx.sv
module pulse_frame_rx
  import pfr_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 50_000_000,
  parameter int SAMPLE_US   = 750,
  parameter int SYNC_US     = 2000,
  parameter int TIMEOUT_US  = 5000,
  parameter int NBYTES      = 12,
  parameter int SYNC_STAGES = 2,
  localparam int NBITS      = 8 * NBYTES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  output logic             frame_valid_o,
  output logic [NBITS-1:0] frame_data_o,
  output logic             frame_err_o
);
  localparam int SAMPLE_CYC  = cyc_from_us(CLK_FREQ_HZ, SAMPLE_US);
  localparam int SYNC_CYC    = cyc_from_us(CLK_FREQ_HZ, SYNC_US);
  localparam int TIMEOUT_CYC = cyc_from_us(CLK_FREQ_HZ, TIMEOUT_US);
  localparam int BCNT_W      = $clog2(NBITS + 1);

  logic line_s, fall, rise;
  logic sample, bit_v, sync_det, tmo;
  logic shift, clr;
  logic [NBITS-1:0]  shreg, assembled, data_d;
  logic [BCNT_W-1:0] bit_cnt;
  logic last_bit;
  rx_state_e state_q;

  pfr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .line_i(line_i),
    .line_o(line_s),
    .fall_o(fall),
    .rise_o(rise)
  );

  pfr_pulse_timer #(
    .SAMPLE_CYC (SAMPLE_CYC),
    .SYNC_CYC   (SYNC_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_i  (line_s),
    .fall_i  (fall),
    .rise_i  (rise),
    .sample_o(sample),
    .bit_o   (bit_v),
    .sync_o  (sync_det),
    .tmo_o   (tmo)
  );

  assign clr   = sync_det;
  assign shift = sample && (state_q == ST_RECV) && !sync_det;

  pfr_shifter #(.NBITS(NBITS)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .shift_i(shift),
    .bit_i  (bit_v),
    .shreg_o(shreg),
    .cnt_o  (bit_cnt)
  );

  assign last_bit  = shift && (bit_cnt == BCNT_W'(NBITS - 1));
  assign assembled = {shreg[NBITS-2:0], bit_v};

  // first received byte lands in the lowest lane
  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    assign data_d[8*k +: 8] = assembled[NBITS-1-8*k -: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      frame_valid_o <= 1'b0;
      frame_err_o   <= 1'b0;
      frame_data_o  <= '0;
    end else begin
      frame_valid_o <= 1'b0;
      frame_err_o   <= 1'b0;
      if (sync_det) begin
        state_q <= ST_RECV;
      end else if (state_q == ST_RECV) begin
        if (last_bit) begin
          state_q       <= ST_IDLE;
          frame_valid_o <= 1'b1;
          frame_data_o  <= data_d;
        end else if (tmo && bit_cnt != '0) begin
          state_q     <= ST_IDLE;
          frame_err_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pulse_frame_rx_chk.sv
module pulse_frame_rx_chk #(
  parameter int NBITS  = 96,
  parameter int BCNT_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_valid_o,
  input logic              frame_err_o,
  input logic [NBITS-1:0]  frame_data_o,
  input logic [BCNT_W-1:0] bit_cnt_i
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |=> !frame_valid_o); // R3

  AST_VALID_FULL_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> (bit_cnt_i == BCNT_W'(NBITS))); // R3

  AST_BITCNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_i <= BCNT_W'(NBITS)); // R3

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_valid_o |-> $stable(frame_data_o)); // R5

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> !frame_err_o); // R6

  AST_VALID_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_valid_o && frame_err_o)); // R6
endmodule

bind pulse_frame_rx pulse_frame_rx_chk #(.NBITS(NBITS), .BCNT_W(BCNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_valid_o(frame_valid_o),
  .frame_err_o  (frame_err_o),
  .frame_data_o (frame_data_o),
  .bit_cnt_i    (bit_cnt)
);

// File: tb/pulse_frame_rx_tb_top.sv
`timescale 1ns/1ps
module pulse_frame_rx_tb_top;
  // 100 kHz nominal: sample 75, marker 200, timeout 500 cycles
  localparam int NBYTES = 12;
  localparam int NBITS  = 8 * NBYTES;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic line_i = 1'b0;
  logic             frame_valid_o;
  logic [NBITS-1:0] frame_data_o;
  logic             frame_err_o;

  int checks = 0;
  int errors = 0;
  int valid_cnt = 0;
  int err_cnt = 0;
  int valid_run = 0;
  int valid_run_max = 0;
  bit done = 1'b0;
  logic [7:0]       bytes_q [NBYTES];
  logic [NBITS-1:0] exp_data = '0;
  logic [NBITS-1:0] last_data = '0;

  always #5 clk_i = ~clk_i;

  pulse_frame_rx #(
    .CLK_FREQ_HZ(100_000),
    .NBYTES     (NBYTES)
  ) dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_i       (line_i),
    .frame_valid_o(frame_valid_o),
    .frame_data_o (frame_data_o),
    .frame_err_o  (frame_err_o)
  );

  always @(negedge clk_i) begin
    if (frame_valid_o) begin
      valid_cnt++;
      valid_run++;
      last_data = frame_data_o;
      if (valid_run > valid_run_max) valid_run_max = valid_run;
    end else begin
      valid_run = 0;
    end
    if (frame_err_o) err_cnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [NBITS-1:0] act,
                     input logic [NBITS-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [NBITS-1:0] pack_bytes();
    logic [NBITS-1:0] d;
    for (int k = 0; k < NBYTES; k++) d[8*k +: 8] = bytes_q[k];
    return d;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send_bit(input bit b);
    int lo;
    int gap;
    if (b) begin
      lo  = 40 + int'($urandom_range(15));
      gap = 90 - lo + int'($urandom_range(20));
    end else begin
      lo  = 90 + int'($urandom_range(20));
      gap = 20 + int'($urandom_range(20));
    end
    line_i = 1'b0; idle(lo);
    line_i = 1'b1; idle(gap);
  endtask

  task automatic send_marker();
    line_i = 1'b0; idle(300);
    line_i = 1'b1; idle(40);
  endtask

  task automatic send_bits(input int nbits);
    for (int i = 0; i < nbits; i++)
      send_bit(bytes_q[i / 8][7 - (i % 8)]);
  endtask

  task automatic end_frame();
    line_i = 1'b0; idle(120);
  endtask

  task automatic rand_bytes();
    for (int k = 0; k < NBYTES; k++) bytes_q[k] = 8'($urandom);
  endtask

  task automatic full_frame_check(input string tag);
    int v0;
    int e0;
    v0 = valid_cnt; e0 = err_cnt;
    exp_data = pack_bytes();
    send_marker();
    send_bits(NBITS);
    end_frame();
    chk(valid_cnt == v0 + 1, {tag, " R3 one frame"}, NBITS'(valid_cnt - v0), NBITS'(1));
    chk(frame_data_o == exp_data, {tag, " R1 R4 data"}, frame_data_o, exp_data);
    chk(err_cnt == e0, {tag, " R3 no err"}, NBITS'(err_cnt - e0), '0);
  endtask

  initial begin
    int v0;
    int e0;
    logic [NBITS-1:0] held;
    void'($urandom(32'd2024));
    idle(3);
    // R10
    chk(!frame_valid_o && !frame_err_o && frame_data_o == '0, "R10 in reset",
        frame_data_o, '0);
    rst_ni = 1'b1;
    idle(5);
    chk(!frame_valid_o && !frame_err_o && frame_data_o == '0, "R10 after reset",
        frame_data_o, '0);
    idle(250);

    // directed pattern: byte order and MSB-first
    for (int k = 0; k < NBYTES; k++) bytes_q[k] = (k % 3 == 0) ? 8'hFF :
                                                   (k % 3 == 1) ? 8'h00 : 8'(8'h80 | k);
    full_frame_check("directed");
    chk(valid_run_max == 1, "R3 strobe width", NBITS'(valid_run_max), NBITS'(1));

    for (int f = 0; f < 3; f++) begin
      rand_bytes();
      full_frame_check("random");
    end

    // R11 / R5: long low idle after a frame
    held = frame_data_o;
    v0 = valid_cnt; e0 = err_cnt;
    idle(900);
    chk(valid_cnt == v0 && err_cnt == e0, "R11 idle low quiet", NBITS'(valid_cnt - v0), '0);
    chk(frame_data_o == held, "R5 hold while idle", frame_data_o, held);

    // R6: truncated frame, line left high
    rand_bytes();
    v0 = valid_cnt; e0 = err_cnt;
    send_marker();
    send_bits(40);
    idle(700);
    chk(err_cnt == e0 + 1, "R6 one err strobe", NBITS'(err_cnt - e0), NBITS'(1));
    chk(valid_cnt == v0, "R6 no valid", NBITS'(valid_cnt - v0), '0);
    chk(frame_data_o == held, "R6 R5 data kept", frame_data_o, held);

    // R8 / R2: short low then bits, no marker
    v0 = valid_cnt; e0 = err_cnt;
    line_i = 1'b0; idle(150);
    line_i = 1'b1; idle(40);
    send_bits(NBITS);
    line_i = 1'b1; idle(700);
    chk(valid_cnt == v0 && err_cnt == e0, "R8 R2 unmarked ignored",
        NBITS'(valid_cnt - v0 + err_cnt - e0), '0);
    chk(frame_data_o == held, "R8 data unchanged", frame_data_o, held);

    // R9: restart marker mid-frame
    rand_bytes();
    v0 = valid_cnt; e0 = err_cnt;
    send_marker();
    send_bits(50);
    rand_bytes();
    full_frame_check("R9 restart");
    chk(valid_cnt == v0 + 1 && err_cnt == e0, "R9 single frame",
        NBITS'(valid_cnt - v0), NBITS'(1));

    // R7: long quiet before bit 0
    rand_bytes();
    exp_data = pack_bytes();
    v0 = valid_cnt; e0 = err_cnt;
    send_marker();
    idle(800);
    chk(err_cnt == e0, "R7 no timeout before bit 0", NBITS'(err_cnt - e0), '0);
    send_bits(NBITS);
    end_frame();
    chk(valid_cnt == v0 + 1, "R7 frame after wait", NBITS'(valid_cnt - v0), NBITS'(1));
    chk(frame_data_o == exp_data, "R7 R4 data", frame_data_o, exp_data);
    chk(valid_run_max == 1, "R3 strobe width final", NBITS'(valid_run_max), NBITS'(1));

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190_000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog act=%0d exp=0", 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule